// File: doc/BRIEF.md
# Stream-to-Memory Ring Buffer Writer

This block drains a valid/ready data stream into a circular region of memory. It writes only fixed-length incrementing bursts on a write channel that has address, data-with-last and response phases. Software sets the region with a start address and an end address. The end address is the byte just past the region. Software also supplies a consumer pointer that marks how far it has read. The engine publishes a written pointer. The bytes from the consumer pointer up to, but not including, the written pointer hold valid data. When the two pointers are equal, the ring is empty.

The stream is held off until the enable input is raised. The enable input is not meant to be lowered again once it is high. Each of the three configured addresses must be a whole multiple of the burst size in bytes. Any address that breaks this rule produces its own error pulse. Other one-cycle pulses report a completed packet and an error write response.

Top module: `ring_stream_writer`

## Requirements
- R1: While `cfg_enable` is 0, `s_ready` and `aw_valid` stay 0 and `wr_ptr` follows `cfg_start_addr`.
- R2: Each burst has `aw_len` = BURST_BEATS-1, `aw_size` = log2(DATA_W/8), `aw_burst` = 2'b01 (incrementing) and `w_strb` all ones. `w_last` is high on beat BURST_BEATS-1 only. Stream words go out in arrival order at consecutive word addresses starting at `aw_addr`.
- R3: Once `aw_valid` is raised, it stays high with `aw_addr` unchanged until `aw_ready` is seen.
- R4: `wr_ptr` advances by one burst (BURST_BEATS*DATA_W/8 bytes) in the cycle after each write response is accepted. When the advanced value would equal `cfg_end_addr`, it takes `cfg_start_addr` instead, so `wr_ptr` never equals the end address while enabled.
- R5: A burst starts only if advancing `wr_ptr` by one burst, with wrap, would not make it equal `cfg_read_addr`. Equal pointers therefore mean empty, and writing is allowed from the empty state.
- R6: A response with `b_resp[1]` set (2'b10 or 2'b11) gives a one-cycle `ev_wr_err` pulse in the cycle after the response. `wr_ptr` still advances.
- R7: `ev_done` pulses for one cycle each time another PKT_BEATS beats have been acknowledged by write responses.
- R8: `ev_start_unal`, `ev_end_unal` and `ev_read_unal` each pulse for one cycle after their address takes a new value whose low log2(burst bytes) bits are not all zero. Holding that value produces no further pulses.
- R9: No burst starts while any of the three configured addresses is misaligned.
- R10: During reset, `s_ready`, `aw_valid`, `w_valid`, `b_ready` and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Starts consumption of the stream |
| cfg_start_addr | input | ADDR_W | First byte of the ring |
| cfg_end_addr | input | ADDR_W | Byte after the last byte of the ring |
| cfg_read_addr | input | ADDR_W | Consumer pointer written by software |
| wr_ptr | output | ADDR_W | Written pointer |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted |
| s_data | input | DATA_W | Stream word |
| aw_valid | output | 1 | Burst address valid |
| aw_ready | input | 1 | Burst address accepted |
| aw_addr | output | ADDR_W | Burst start byte address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | log2 of bytes per beat |
| aw_burst | output | 2 | Burst type, incrementing |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data accepted |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Byte strobes |
| w_last | output | 1 | Final beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response accepted |
| b_resp | input | 2 | Write response code |
| ev_done | output | 1 | Packet completed pulse |
| ev_wr_err | output | 1 | Error response pulse |
| ev_start_unal | output | 1 | Start address misaligned pulse |
| ev_end_unal | output | 1 | End address misaligned pulse |
| ev_read_unal | output | 1 | Consumer pointer misaligned pulse |

## Verification
The hardest state to reach is the full ring, where exactly one burst slot is left and the engine must refuse it. It is closely followed by the wrap in which the pointer returns to the start without ever showing the end address. The stimulus queues more words than the ring can take while the consumer pointer sits at the start. It then checks that the engine stops one burst short. Next it moves the consumer pointer so that the pending burst lands in the last slot and wraps the pointer. Throttled address and data ready signals stretch each burst, and a consumer pointer left misaligned shows that queued data is held back.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } burst_st_t;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // SLVERR and DECERR both carry bit 1
    function automatic logic resp_is_err(input logic [1:0] r);
        return r[1];
    endfunction
endpackage

// File: rtl/rsw_align_watch.sv
module rsw_align_watch #(
    parameter int ADDR_W = 16,
    parameter int LSB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic              mis,
    output logic              ev
);
    logic              seen;
    logic [ADDR_W-1:0] prev;

    assign mis = |addr[LSB_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            prev <= '0;
            ev   <= 1'b0;
        end else begin
            seen <= 1'b1;
            prev <= addr;
            ev   <= mis && (!seen || addr != prev);
        end
    end
endmodule

// File: rtl/rsw_ring_ptr.sv
module rsw_ring_ptr #(
    parameter int ADDR_W      = 16,
    parameter int BURST_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] end_a,
    input  logic [ADDR_W-1:0] read_a,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr,
    output logic              room
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] nxt;

    assign inc  = ptr + STEP;
    assign nxt  = (inc == end_a) ? start_a : inc;
    assign room = (nxt != read_a);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (!enable) begin
            ptr <= start_a;
        end else if (advance) begin
            ptr <= nxt;
        end
    end
endmodule

// File: rtl/rsw_burst_fsm.sv
module rsw_burst_fsm
    import rsw_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4,
    parameter int PKT_BEATS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [DATA_W-1:0] w_data,
    output logic              w_last,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [1:0]        b_resp,
    output logic              advance,
    output logic              ev_done,
    output logic              ev_wr_err
);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
    localparam int PKT_W  = $clog2(PKT_BEATS + BURST_BEATS + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);
    localparam logic [PKT_W-1:0]  PKT_LIM   = PKT_W'(PKT_BEATS);
    localparam logic [PKT_W-1:0]  PKT_STEP  = PKT_W'(BURST_BEATS);

    burst_st_t         st;
    logic [BEAT_W-1:0] beat;
    logic [PKT_W-1:0]  pkt_cnt;
    logic [PKT_W-1:0]  pkt_sum;
    logic              w_hs;

    assign aw_valid = (st == ST_ADDR);
    assign s_ready  = (st == ST_DATA) && w_ready;
    assign w_valid  = (st == ST_DATA) && s_valid;
    assign w_data   = s_data;
    assign w_last   = (st == ST_DATA) && (beat == LAST_BEAT);
    assign b_ready  = (st == ST_RESP);
    assign advance  = (st == ST_RESP) && b_valid;
    assign w_hs     = w_valid && w_ready;
    assign pkt_sum  = pkt_cnt + PKT_STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            beat      <= '0;
            pkt_cnt   <= '0;
            ev_done   <= 1'b0;
            ev_wr_err <= 1'b0;
        end else begin
            ev_done   <= 1'b0;
            ev_wr_err <= 1'b0;
            unique case (st)
                ST_IDLE: if (go) st <= ST_ADDR;
                ST_ADDR: if (aw_ready) begin
                    st   <= ST_DATA;
                    beat <= '0;
                end
                ST_DATA: if (w_hs) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST_BEAT) st <= ST_RESP;
                end
                ST_RESP: if (b_valid) begin
                    st        <= ST_IDLE;
                    ev_wr_err <= resp_is_err(b_resp);
                    if (pkt_sum >= PKT_LIM) begin
                        pkt_cnt <= pkt_sum - PKT_LIM;
                        ev_done <= 1'b1;
                    end else begin
                        pkt_cnt <= pkt_sum;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_stream_writer.sv
module ring_stream_writer
    import rsw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4,
    parameter int PKT_BEATS   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic [ADDR_W-1:0]   cfg_start_addr,
    input  logic [ADDR_W-1:0]   cfg_end_addr,
    input  logic [ADDR_W-1:0]   cfg_read_addr,
    output logic [ADDR_W-1:0]   wr_ptr,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [DATA_W-1:0]   s_data,
    output logic                aw_valid,
    input  logic                aw_ready,
    output logic [ADDR_W-1:0]   aw_addr,
    output logic [7:0]          aw_len,
    output logic [2:0]          aw_size,
    output logic [1:0]          aw_burst,
    output logic                w_valid,
    input  logic                w_ready,
    output logic [DATA_W-1:0]   w_data,
    output logic [DATA_W/8-1:0] w_strb,
    output logic                w_last,
    input  logic                b_valid,
    output logic                b_ready,
    input  logic [1:0]          b_resp,
    output logic                ev_done,
    output logic                ev_wr_err,
    output logic                ev_start_unal,
    output logic                ev_end_unal,
    output logic                ev_read_unal
);
    localparam int STRB_W      = DATA_W / 8;
    localparam int BURST_BYTES = BURST_BEATS * STRB_W;
    localparam int LSB_W       = $clog2(BURST_BYTES);
    localparam int SIZE_CODE   = $clog2(STRB_W);
    localparam int N_CFG       = 3;

    logic [ADDR_W-1:0] cfg_addrs [N_CFG];
    logic [N_CFG-1:0]  mis;
    logic [N_CFG-1:0]  ev_unal;
    logic              room;
    logic              advance;
    logic              go;

    assign cfg_addrs[0] = cfg_start_addr;
    assign cfg_addrs[1] = cfg_end_addr;
    assign cfg_addrs[2] = cfg_read_addr;

    generate
        for (genvar i = 0; i < N_CFG; i++) begin : g_align
            rsw_align_watch #(
                .ADDR_W (ADDR_W),
                .LSB_W  (LSB_W)
            ) u_watch (
                .clk  (clk),
                .rst  (rst),
                .addr (cfg_addrs[i]),
                .mis  (mis[i]),
                .ev   (ev_unal[i])
            );
        end
    endgenerate

    assign ev_start_unal = ev_unal[0];
    assign ev_end_unal   = ev_unal[1];
    assign ev_read_unal  = ev_unal[2];

    rsw_ring_ptr #(
        .ADDR_W      (ADDR_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg_enable),
        .start_a (cfg_start_addr),
        .end_a   (cfg_end_addr),
        .read_a  (cfg_read_addr),
        .advance (advance),
        .ptr     (wr_ptr),
        .room    (room)
    );

    assign go = cfg_enable && !(|mis) && room && s_valid;

    rsw_burst_fsm #(
        .DATA_W      (DATA_W),
        .BURST_BEATS (BURST_BEATS),
        .PKT_BEATS   (PKT_BEATS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .aw_valid  (aw_valid),
        .aw_ready  (aw_ready),
        .w_valid   (w_valid),
        .w_ready   (w_ready),
        .w_data    (w_data),
        .w_last    (w_last),
        .b_valid   (b_valid),
        .b_ready   (b_ready),
        .b_resp    (b_resp),
        .advance   (advance),
        .ev_done   (ev_done),
        .ev_wr_err (ev_wr_err)
    );

    assign aw_addr  = wr_ptr;
    assign aw_len   = 8'(BURST_BEATS - 1);
    assign aw_size  = 3'(SIZE_CODE);
    assign aw_burst = BURST_INCR;
    assign w_strb   = '1;
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_enable,
    input logic [ADDR_W-1:0] cfg_start_addr,
    input logic [ADDR_W-1:0] cfg_end_addr,
    input logic [ADDR_W-1:0] cfg_read_addr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              s_ready,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [ADDR_W-1:0] aw_addr,
    input logic              b_valid,
    input logic              b_ready,
    input logic [1:0]        b_resp,
    input logic              ev_wr_err,
    input logic              ev_read_unal
);
    localparam int BURST_BYTES = BURST_BEATS * (DATA_W / 8);
    localparam int LSB_W       = $clog2(BURST_BYTES);

    logic [ADDR_W-1:0] aw_inc;
    logic [ADDR_W-1:0] aw_nxt;
    assign aw_inc = aw_addr + ADDR_W'(BURST_BYTES);
    assign aw_nxt = (aw_inc == cfg_end_addr) ? cfg_start_addr : aw_inc;

    assert_stall_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> !s_ready && !aw_valid);

    assert_aw_hold_R3: assert property (@(posedge clk) disable iff (rst)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr));

    assert_never_end_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_enable |-> wr_ptr != cfg_end_addr);

    assert_ptr_on_resp_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_enable && $past(cfg_enable) && !$stable(wr_ptr) |-> $past(b_valid && b_ready));

    assert_not_full_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(aw_valid) |-> aw_nxt != $past(cfg_read_addr));

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        b_valid && b_ready && b_resp[1] |=> ev_wr_err);

    assert_read_unal_R8: assert property (@(posedge clk) disable iff (rst)
        ev_read_unal |-> $past(|cfg_read_addr[LSB_W-1:0]));
endmodule

bind ring_stream_writer rsw_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BURST_BEATS (BURST_BEATS)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_enable     (cfg_enable),
    .cfg_start_addr (cfg_start_addr),
    .cfg_end_addr   (cfg_end_addr),
    .cfg_read_addr  (cfg_read_addr),
    .wr_ptr         (wr_ptr),
    .s_ready        (s_ready),
    .aw_valid       (aw_valid),
    .aw_ready       (aw_ready),
    .aw_addr        (aw_addr),
    .b_valid        (b_valid),
    .b_ready        (b_ready),
    .b_resp         (b_resp),
    .ev_wr_err      (ev_wr_err),
    .ev_read_unal   (ev_read_unal)
);

// File: tb/ring_stream_writer_tb.sv
module ring_stream_writer_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_enable = 1'b0;
    logic [AW-1:0] cfg_start_addr = 16'h0100;
    logic [AW-1:0] cfg_end_addr   = 16'h0140;
    logic [AW-1:0] cfg_read_addr  = 16'h0100;
    logic [AW-1:0] wr_ptr;
    logic          s_valid, s_ready;
    logic [DW-1:0] s_data;
    logic          aw_valid, aw_ready;
    logic [AW-1:0] aw_addr;
    logic [7:0]    aw_len;
    logic [2:0]    aw_size;
    logic [1:0]    aw_burst;
    logic          w_valid, w_ready, w_last;
    logic [DW-1:0] w_data;
    logic [3:0]    w_strb;
    logic          b_valid = 1'b0, b_ready;
    logic [1:0]    b_resp;
    logic          ev_done, ev_wr_err, ev_start_unal, ev_end_unal, ev_read_unal;

    always #2.5 clk = ~clk;

    ring_stream_writer u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
        .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
        .cfg_read_addr(cfg_read_addr), .wr_ptr(wr_ptr),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .ev_done(ev_done), .ev_wr_err(ev_wr_err),
        .ev_start_unal(ev_start_unal), .ev_end_unal(ev_end_unal),
        .ev_read_unal(ev_read_unal)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // stream source
    logic [DW-1:0] src_mem [0:255];
    int src_rd = 0;
    int src_wr = 0;
    logic [DW-1:0] exp_q [$];
    assign s_valid = (src_rd < src_wr);
    assign s_data  = src_mem[src_rd[7:0]];

    always @(posedge clk) if (s_valid && s_ready) src_rd <= src_rd + 1;

    task automatic push_beats(input int n);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] v;
            v = 32'hA500_0000 + 32'(src_wr);
            src_mem[src_wr[7:0]] = v;
            exp_q.push_back(v);
            src_wr++;
        end
    endtask

    // memory responder with throttling
    int cyc = 0;
    logic err_mode = 1'b0;
    logic b_pend = 1'b0;
    assign aw_ready = (cyc % 3) != 0;
    assign w_ready  = (cyc % 4) != 1;
    assign b_resp   = err_mode ? 2'b10 : 2'b00;
    always @(negedge clk) begin
        cyc++;
        b_valid <= b_pend;
    end

    // monitor / scoreboard
    logic [AW-1:0] mdl_aw = 16'h0100;
    logic [AW-1:0] cur_addr = '0;
    int beat = 0;
    int aw_cnt = 0, done_cnt = 0, err_cnt = 0;
    int st_cnt = 0, en_cnt = 0, rd_cnt = 0, dis_rdy = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (!cfg_enable && (s_ready || aw_valid)) dis_rdy++;
            if (ev_done) done_cnt++;
            if (ev_wr_err) err_cnt++;
            if (ev_start_unal) st_cnt++;
            if (ev_end_unal) en_cnt++;
            if (ev_read_unal) rd_cnt++;
            if (aw_valid && aw_ready) begin
                chk(aw_addr == mdl_aw, "R4 burst address", aw_addr, mdl_aw);
                chk(aw_len == 8'd3 && aw_size == 3'd2 && aw_burst == 2'b01,
                    "R2 burst attributes", {aw_len, aw_size, aw_burst}, {8'd3, 3'd2, 2'b01});
                cur_addr = aw_addr;
                beat = 0;
                aw_cnt++;
                mdl_aw = (mdl_aw + 16'd16 == 16'h0140) ? 16'h0100 : mdl_aw + 16'd16;
            end
            if (w_valid && w_ready) begin
                logic [DW-1:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
                chk(w_data == e, "R2 data order", w_data, e);
                chk(w_strb == 4'hF, "R2 strobes", w_strb, 4'hF);
                chk(w_last == (beat == 3), "R2 last beat", w_last, (beat == 3));
                if (w_last) b_pend = 1'b1;
                beat++;
            end
            if (b_valid && b_ready) b_pend = 1'b0;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!s_ready && !aw_valid && !w_valid && !b_ready, "R10 handshakes in reset",
            {s_ready, aw_valid, w_valid, b_ready}, 0);
        chk({ev_done, ev_wr_err, ev_start_unal, ev_end_unal, ev_read_unal} == 0,
            "R10 events in reset", {ev_done, ev_wr_err, ev_start_unal, ev_end_unal, ev_read_unal}, 0);
        rst = 1'b0;

        // R1: stalled while disabled
        push_beats(16);
        repeat (20) @(negedge clk);
        chk(dis_rdy == 0, "R1 no ready before enable", dis_rdy, 0);
        chk(src_rd == 0, "R1 nothing consumed", src_rd, 0);
        chk(wr_ptr == 16'h0100, "R1 pointer follows start", wr_ptr, 16'h0100);

        // R5: ring fills one burst short of the consumer pointer
        cfg_enable = 1'b1;
        repeat (150) @(negedge clk);
        chk(aw_cnt == 3, "R5 stops one slot short", aw_cnt, 3);
        chk(wr_ptr == 16'h0130, "R4 pointer after three bursts", wr_ptr, 16'h0130);
        chk(src_rd == 12, "R5 beats consumed", src_rd, 12);
        chk(done_cnt == 1, "R7 one packet done", done_cnt, 1);

        // R4: last slot then wrap to start
        cfg_read_addr = 16'h0130;
        repeat (80) @(negedge clk);
        chk(wr_ptr == 16'h0100, "R4 wrap to start", wr_ptr, 16'h0100);
        chk(aw_cnt == 4, "R4 fourth burst", aw_cnt, 4);
        chk(done_cnt == 2, "R7 second packet", done_cnt, 2);

        // R6: error response still advances
        err_mode = 1'b1;
        push_beats(4);
        repeat (60) @(negedge clk);
        err_mode = 1'b0;
        chk(err_cnt == 1, "R6 error pulse", err_cnt, 1);
        chk(wr_ptr == 16'h0110, "R6 pointer advances on error", wr_ptr, 16'h0110);

        // R8/R9: misaligned consumer pointer
        cfg_read_addr = 16'h0118;
        repeat (5) @(negedge clk);
        push_beats(4);
        repeat (60) @(negedge clk);
        chk(rd_cnt == 1, "R8 read misaligned pulse once", rd_cnt, 1);
        chk(aw_cnt == 5 && wr_ptr == 16'h0110, "R9 blocked while misaligned", aw_cnt, 5);
        chk(src_rd == 20, "R9 no beats taken", src_rd, 20);
        cfg_read_addr = 16'h0130;
        repeat (60) @(negedge clk);
        chk(wr_ptr == 16'h0120, "R9 resumes when aligned", wr_ptr, 16'h0120);
        chk(done_cnt == 3, "R7 third packet", done_cnt, 3);

        // R5: writing allowed from the empty state
        cfg_read_addr = 16'h0120;
        push_beats(4);
        repeat (60) @(negedge clk);
        chk(wr_ptr == 16'h0130, "R5 write from empty", wr_ptr, 16'h0130);

        // R8: start and end misalignment
        cfg_end_addr = 16'h0144;
        repeat (6) @(negedge clk);
        cfg_end_addr = 16'h0140;
        cfg_start_addr = 16'h0104;
        repeat (6) @(negedge clk);
        cfg_start_addr = 16'h0100;
        repeat (4) @(negedge clk);
        chk(en_cnt == 1, "R8 end misaligned pulse", en_cnt, 1);
        chk(st_cnt == 1, "R8 start misaligned pulse", st_cnt, 1);
        chk(rd_cnt == 1, "R8 no extra read pulse", rd_cnt, 1);
        chk(exp_q.size() == 0, "R2 all data written", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule